// File: doc/BRIEF.md
# PCI Target Control State Machine

This block is the target-side controller of a 32-bit PCI interface. It watches the address phase (FRAME#, IRDY#, the command on C/BE#, and the hit lines from the base address decoders). It decides whether the cycle is one it takes. If it takes the cycle, it drives DEVSEL#, TRDY# and STOP# and a shared output enable for those three lines. The datapath, parity and bus mastering are handled elsewhere.

The claim is made with medium decode timing. Writes run with zero wait states from the first data phase. Reads wait one extra turnaround clock and then also move one word per clock. The user logic can ask for a retry, a disconnect or a target abort through three request inputs. It receives three strobes: one when a claimed access starts, one for each data phase that completes, and one that gives the direction.

Top module: `pci_tgt_ctl`

## Requirements
- R1: While reset is low, the output enable is low, DEVSEL#, TRDY# and STOP# read high, and the strobes addr_vld, data_done and rd_dir are low.
- R2: Commands 0000, 0010, 0011, 0110, 0111, 1010, 1011, 1100, 1110 and 1111 are claimed when at least one hit line is high during the address phase. The address phase is the first clock with FRAME# low after a clock with FRAME# high, with IRDY# high. DEVSEL# goes low in the second clock after the address phase, and addr_vld is high in exactly that clock.
- R3: Commands 0001, 0100, 0101, 1000, 1001 and 1101 are never claimed, nor is any command with no hit line high. The output enable stays low for the whole transaction.
- R4: For write commands (C/BE# bit 0 = 1), TRDY# goes low in the same clock as DEVSEL#. It stays low for each clock of the burst, with no wait states.
- R5: For read commands (C/BE# bit 0 = 0), TRDY# first goes low one clock after DEVSEL#. rd_dir is high while a claimed read drives the bus, except in the release clock.
- R6: data_done is high exactly in the clocks where the target drives TRDY# low and IRDY# is low.
- R7: After the final data phase completes (FRAME# high, IRDY# and TRDY# low), all three control lines are driven high for one clock. The output enable then goes low.
- R8: A retry or disconnect request sampled at the end of the decode clock, or during the read turnaround clock, gives STOP# low with DEVSEL# low and TRDY# high. No data moves.
- R9: A retry or disconnect request sampled during a data clock ends the burst. The next clock has STOP# and DEVSEL# low and TRDY# high.
- R10: A target abort request gives STOP# low with DEVSEL# and TRDY# high. It takes priority over retry and disconnect. It has no effect when no cycle is claimed.
- R11: STOP# stays low until FRAME# is seen high. The one-clock release of R7 then follows.
- R12: Exactly one state bit is set in every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | FRAME# from the bus |
| irdy_n | input | 1 | IRDY# from the bus |
| cbe_n | input | CMD_W | Command / byte enables |
| bar_hit | input | NUM_BAR | Address decoder hit lines, valid in the address phase |
| usr_retry | input | 1 | User asks for retry |
| usr_disc | input | 1 | User asks for disconnect |
| usr_abort | input | 1 | User asks for target abort |
| devsel_n | output | 1 | DEVSEL# drive value |
| trdy_n | output | 1 | TRDY# drive value |
| stop_n | output | 1 | STOP# drive value |
| ctl_oe | output | 1 | Output enable for DEVSEL#, TRDY#, STOP# |
| addr_vld | output | 1 | Pulse in the first claimed clock |
| data_done | output | 1 | A data phase completes this clock |
| rd_dir | output | 1 | Claimed cycle is a read |

## Verification
The checker watches several rules in every clock. It checks that the state stays one-hot. It checks that TRDY# never goes low without DEVSEL#, that an abort never shows TRDY# low, and that data_done appears only together with TRDY# and IRDY# low. It checks that DEVSEL# falls only in the addr_vld clock, that STOP# holds while FRAME# is low, and that the enable drops only after a clock with all lines high. The claim table, the exact clock of the first TRDY# for reads and writes, the burst lengths, and the priority of abort over the other requests depend on the command and request timing. Only the bench's transaction scenarios, compared against its reference model, can show those.

// File: rtl/pci_tgt_ctl.sv
module pci_tgt_ctl #(
  parameter int NUM_BAR = 3,
  parameter int CMD_W = 4,
  parameter logic [(1<<CMD_W)-1:0] CLAIM_MAP = 16'hDCCD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic [CMD_W-1:0]   cbe_n,
  input  logic [NUM_BAR-1:0] bar_hit,
  input  logic               usr_retry,
  input  logic               usr_disc,
  input  logic               usr_abort,
  output logic               devsel_n,
  output logic               trdy_n,
  output logic               stop_n,
  output logic               ctl_oe,
  output logic               addr_vld,
  output logic               data_done,
  output logic               rd_dir
);
  localparam int S_IDLE = 0;
  localparam int S_DEC  = 1;
  localparam int S_TURN = 2;
  localparam int S_DATA = 3;
  localparam int S_STOP = 4;
  localparam int S_ABT  = 5;
  localparam int S_OFF  = 6;
  localparam int NS     = 7;

  logic [NS-1:0]    state, nxt;
  logic             frame_q, first_q, first_d;
  logic [CMD_W-1:0] cmd_q;
  logic             hit_q;

  wire addr_ph = state[S_IDLE] & ~frame_n & frame_q & irdy_n;
  wire claim   = CLAIM_MAP[cmd_q] & hit_q;
  wire is_rd   = ~cmd_q[0];
  wire term    = usr_retry | usr_disc;
  wire last_ok = ~irdy_n & frame_n;

  always_comb begin
    nxt     = '0;
    first_d = 1'b0;
    case (1'b1)
      state[S_IDLE]: if (addr_ph) nxt[S_DEC] = 1'b1; else nxt[S_IDLE] = 1'b1;
      state[S_DEC]: begin
        if (!claim)         nxt[S_IDLE] = 1'b1;
        else if (usr_abort) nxt[S_ABT]  = 1'b1;
        else begin
          first_d = 1'b1;
          if (term)       nxt[S_STOP] = 1'b1;
          else if (is_rd) nxt[S_TURN] = 1'b1;
          else            nxt[S_DATA] = 1'b1;
        end
      end
      state[S_TURN]: begin
        if (usr_abort) nxt[S_ABT]  = 1'b1;
        else if (term) nxt[S_STOP] = 1'b1;
        else           nxt[S_DATA] = 1'b1;
      end
      state[S_DATA]: begin
        if (last_ok)        nxt[S_OFF]  = 1'b1;
        else if (usr_abort) nxt[S_ABT]  = 1'b1;
        else if (term)      nxt[S_STOP] = 1'b1;
        else                nxt[S_DATA] = 1'b1;
      end
      state[S_STOP]: if (frame_n) nxt[S_OFF] = 1'b1; else nxt[S_STOP] = 1'b1;
      state[S_ABT]:  if (frame_n) nxt[S_OFF] = 1'b1; else nxt[S_ABT]  = 1'b1;
      default:       nxt[S_IDLE] = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= NS'(1) << S_IDLE;
      frame_q <= 1'b1;
      first_q <= 1'b0;
      cmd_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      state   <= nxt;
      frame_q <= frame_n;
      first_q <= first_d;
      if (addr_ph) begin
        cmd_q <= cbe_n;
        hit_q <= |bar_hit;
      end
    end
  end

  assign devsel_n  = ~(state[S_TURN] | state[S_DATA] | state[S_STOP]);
  assign trdy_n    = ~state[S_DATA];
  assign stop_n    = ~(state[S_STOP] | state[S_ABT]);
  assign ctl_oe    = ~(state[S_IDLE] | state[S_DEC]);
  assign addr_vld  = first_q;
  assign data_done = state[S_DATA] & ~irdy_n;
  assign rd_dir    = is_rd & (state[S_TURN] | state[S_DATA] | state[S_STOP] | state[S_ABT]);
endmodule

// File: rtl/pci_tgt_ctl_chk.sv
module pci_tgt_ctl_chk #(
  parameter int NS = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_n,
  input logic          irdy_n,
  input logic          devsel_n,
  input logic          trdy_n,
  input logic          stop_n,
  input logic          ctl_oe,
  input logic          addr_vld,
  input logic          data_done,
  input logic [NS-1:0] state
);
  assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state) == 1);

  assert_trdy_devsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  assert_abort_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && devsel_n) |-> trdy_n);

  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |-> (!irdy_n && !trdy_n));

  assert_medium_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> addr_vld);

  assert_claim_after_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |-> $past(!ctl_oe));

  assert_stop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !frame_n) |=> !stop_n);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_oe) |-> $past(devsel_n && trdy_n && stop_n));
endmodule

bind pci_tgt_ctl pci_tgt_ctl_chk #(.NS(NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe),
  .addr_vld(addr_vld), .data_done(data_done), .state(state)
);

// File: tb/pci_tgt_ctl_tb.sv
`timescale 1ns/1ps
module pci_tgt_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1;
  logic [3:0] cbe_n = '0;
  logic [2:0] bar_hit = '0;
  logic usr_retry = 1'b0, usr_disc = 1'b0, usr_abort = 1'b0;
  logic devsel_n, trdy_n, stop_n, ctl_oe, addr_vld, data_done, rd_dir;

  always #2.5 clk = ~clk;

  pci_tgt_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .bar_hit(bar_hit), .usr_retry(usr_retry), .usr_disc(usr_disc), .usr_abort(usr_abort),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe),
    .addr_vld(addr_vld), .data_done(data_done), .rd_dir(rd_dir)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  localparam logic [15:0] TAKES = 16'hDCCD;

  // reference: 0 idle, 1 decode, 2 read wait, 3 transfer, 4 stop, 5 abort, 6 release
  int st = 0;
  bit fprev = 1, mfirst = 0, mrd = 0, mhit = 0;
  logic [3:0] mcmd = '0;
  bit x_dd, x_stop;
  int x_st;

  task automatic cyc(input string req);
    logic [6:0] got, exp;
    #1;
    exp = {st inside {2,3,4,5,6}, !(st inside {2,3,4}), st != 3, !(st inside {4,5}),
           mfirst, mrd && (st inside {2,3,4,5}), st == 3 && !irdy_n};
    got = {ctl_oe, devsel_n, trdy_n, stop_n, addr_vld, rd_dir, data_done};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s oe/dev/trdy/stop/av/rd/dd got=%b exp=%b t=%0t", req, got, exp, $time);
    end
    x_dd = exp[0]; x_stop = exp[3]; x_st = st;
    @(posedge clk);
    mfirst = 0;
    case (st)
      0: if (!frame_n && fprev && irdy_n) begin st = 1; mcmd = cbe_n; mhit = |bar_hit; mrd = !cbe_n[0]; end
      1: if (!(TAKES[mcmd] && mhit)) st = 0;
         else if (usr_abort) st = 5;
         else begin mfirst = 1; st = (usr_retry || usr_disc) ? 4 : (mrd ? 2 : 3); end
      2: st = usr_abort ? 5 : ((usr_retry || usr_disc) ? 4 : 3);
      3: if (!irdy_n && frame_n) st = 6;
         else if (usr_abort) st = 5;
         else if (usr_retry || usr_disc) st = 4;
      4, 5: if (frame_n) st = 6;
      default: st = 0;
    endcase
    fprev = frame_n;
    @(negedge clk);
  endtask

  // term: 0 none, 1 retry, 2 disconnect, 3 abort, 4 abort together with retry
  task automatic txn(input logic [3:0] cmd, input logic [2:0] hit, input int nd,
                     input int term, input int term_at, input string req);
    int left = nd;
    bit stopped = 0;
    frame_n = 0; irdy_n = 1; cbe_n = cmd; bar_hit = hit;
    cyc(req);
    for (int idx = 1; idx < 60; idx++) begin
      irdy_n = 0; cbe_n = '0; bar_hit = '0;
      frame_n = (left <= 1) || stopped || (st == 0);
      usr_retry = (term == 1 || term == 4) && idx == term_at;
      usr_disc  = (term == 2) && idx == term_at;
      usr_abort = (term == 3 || term == 4) && idx == term_at;
      cyc(req);
      usr_retry = 0; usr_disc = 0; usr_abort = 0;
      if (x_dd) left--;
      if (!x_stop) stopped = 1;
      if (frame_n && (x_dd || !x_stop || x_st == 0)) break;
    end
    frame_n = 1; irdy_n = 1;
    cyc(req); cyc(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    total++;
    if ({ctl_oe, devsel_n, trdy_n, stop_n, addr_vld, data_done, rd_dir} !== 7'b0111000) begin
      bad++;
      $display("FAIL R1 reset got=%b exp=0111000",
               {ctl_oe, devsel_n, trdy_n, stop_n, addr_vld, data_done, rd_dir});
    end
    @(negedge clk);
    rst_n = 1;
    cyc("R1"); cyc("R1");
    // R4 R6 R7: write bursts, zero wait
    txn(4'b0111, 3'b001, 1, 0, 0, "R4");
    txn(4'b0111, 3'b010, 6, 0, 0, "R4");
    txn(4'b1111, 3'b100, 3, 0, 0, "R7");
    // R5: read bursts with turnaround
    txn(4'b0110, 3'b001, 5, 0, 0, "R5");
    txn(4'b1100, 3'b010, 1, 0, 0, "R5");
    // R2: every claimed code
    for (int c = 0; c < 16; c++)
      if (TAKES[c]) txn(4'(c), 3'b001, 2, 0, 0, "R2");
    // R3: ignored codes and no hit
    for (int c = 0; c < 16; c++)
      if (!TAKES[c]) txn(4'(c), 3'b111, 3, 0, 0, "R3");
    txn(4'b0110, 3'b000, 3, 0, 0, "R3");
    // R8: retry at decode and in turnaround
    txn(4'b0111, 3'b001, 4, 1, 1, "R8");
    txn(4'b0110, 3'b001, 4, 2, 2, "R8");
    // R9 R11: disconnect mid burst
    txn(4'b0111, 3'b001, 8, 2, 4, "R9");
    txn(4'b1110, 3'b010, 8, 1, 5, "R11");
    // R10: abort at decode, in data, with retry, and while idle
    txn(4'b0011, 3'b001, 3, 3, 1, "R10");
    txn(4'b0110, 3'b001, 6, 3, 4, "R10");
    txn(4'b0111, 3'b001, 4, 4, 1, "R10");
    usr_abort = 1; usr_retry = 1;
    cyc("R10"); cyc("R10");
    usr_abort = 0; usr_retry = 0;
    cyc("R10");
    // R12 exercised throughout by the checker; final back-to-back writes
    txn(4'b0111, 3'b001, 2, 0, 0, "R12");
    txn(4'b1011, 3'b001, 2, 0, 0, "R12");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule